// File: doc/BRIEF.md
# Queued Point-Plot Graphics Engine

This block sits between a processor and a frame buffer. The processor posts short graphics commands into a command queue. The queue never makes a caller wait while earlier work is still running. Behind the queue, a small sequencer works through the commands one at a time. It keeps a current pen position in 16.16 fixed-point form and a current 16-bit colour. On a plot command it writes that colour to one pixel of a 400 by 300 screen.

The frame buffer is organised as 64-bit words, each holding four 16-bit pixels. A plot works out the linear pixel index from the integer parts of the pen coordinates. It then issues one write request carrying the word address, a one-hot lane enable for the pixel inside that word, and the colour. The request is held until the memory acknowledges it.

Each activation of the sequencer handles exactly one queued command and then returns to its idle state. The queue's output reads as zero after reset, and zero is the do-nothing code, so an empty or freshly reset queue never draws anything.

Top module: `gfx_plot_engine`

## Requirements
- R1: After reset, `mem_req` and `cmd_full` are both low, and no memory write occurs until a plot command has been queued.
- R2: Command code 0 is a NOP: it changes no state and causes no memory access.
- R3: Code 1 loads the X pen register and code 2 loads the Y pen register from `cmd_arg`, in 16.16 fixed-point form. Only bits 31:16, read as a signed integer, select the pixel. The fraction bits have no effect on any write.
- R4: Code 3 loads the current colour from `cmd_arg[15:0]`. Later plots use that colour until it is changed.
- R5: Code 4 plots a pixel. The pixel index is p = y*400 + x, using the integer parts, and `mem_addr` = p >> 2.
- R6: During a plot write, `mem_lane_en` has exactly one bit set, at bit position p mod 4 (equal to x mod 4). `mem_wdata` carries the colour in all four 16-bit lanes.
- R7: A plot whose integer X is outside 0..399, or whose integer Y is outside 0..299, makes no memory access. Negative values count as outside.
- R8: `mem_req`, `mem_addr`, `mem_lane_en` and `mem_wdata` stay steady until a cycle in which `mem_ack` is high. One plot produces exactly one acknowledged write, and `mem_req` is low in the cycle after the acknowledge.
- R9: Commands are executed in the order they were accepted. Commands keep being accepted while a plot waits for its acknowledge.
- R10: `cmd_full` is high when the queue holds FIFO_DEPTH entries. A write while full is refused and does not disturb any queued entry.
- R11: Codes 5 to 15 behave as NOPs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_op | input | 4 | Command code |
| cmd_arg | input | 32 | Command argument |
| cmd_full | output | 1 | Queue full; writes are refused |
| mem_req | output | 1 | Frame-buffer write request |
| mem_addr | output | 15 | Word address |
| mem_lane_en | output | 4 | One-hot 16-bit lane enable |
| mem_wdata | output | 64 | Write data, colour in every lane |
| mem_ack | input | 1 | Write acknowledge |

## Verification
The assertions assume that `mem_ack` is raised only while `mem_req` is high and lasts a single cycle per request. They also assume that the processor side treats `cmd_full` as a refusal.

The bench's memory responder holds to this by acknowledging only a pending request, after a random delay of zero to two cycles. Random pen coordinates deliberately stray a few pixels past every screen edge, including negative values, so that discarded plots occur alongside valid ones. The single deliberate write into a full queue is made with the acknowledge withheld, so the refusal is visible in the count and order of the writes that follow.

// File: rtl/gfx_plot_pkg.sv
// Shared command codes and widths for the point-plot engine.
// Assumes a 64-bit memory word split into four 16-bit pixel lanes.
package gfx_plot_pkg;
    localparam int PIX_BITS  = 16;
    localparam int LANES     = 4;
    localparam int WORD_BITS = PIX_BITS * LANES;
    localparam int OP_BITS   = 4;
    localparam int ARG_BITS  = 32;

    typedef enum logic [OP_BITS-1:0] {
        OP_NOP   = 4'd0,
        OP_SET_X = 4'd1,
        OP_SET_Y = 4'd2,
        OP_COLOR = 4'd3,
        OP_PLOT  = 4'd4
    } gfx_op_e;

    typedef struct packed {
        logic [OP_BITS-1:0]  op;
        logic [ARG_BITS-1:0] arg;
    } gfx_cmd_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_EXEC  = 2'd1,
        SEQ_WRITE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/gfx_cmd_fifo.sv
// Command queue: show-ahead FIFO with count-based full/empty flags.
// Assumes the reader pops only when not empty. A push while full is
// dropped. Storage is cleared on reset, so the output reads as zero.
module gfx_cmd_fifo #(
    parameter int DW    = 36,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] slots [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;
    logic          do_push, do_pop;

    assign full    = (fill == CW'(DEPTH));
    assign empty   = (fill == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots[rd_ptr];

    // Storage write and reset clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (do_push) begin
            slots[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            fill <= fill + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/gfx_pix_addr.sv
// Converts 16.16 fixed-point pen coordinates into a word address and
// one-hot lane enable. Purely combinational. Assumes the screen width
// and height are positive and that their product fits PIXW bits.
module gfx_pix_addr #(
    parameter int SCR_W = 400,
    parameter int SCR_H = 300,
    parameter int LANES = 4
) (
    input  logic [31:0]                          pos_x,
    input  logic [31:0]                          pos_y,
    output logic                                 in_range,
    output logic [$clog2(SCR_W*SCR_H)-$clog2(LANES)-1:0] word_addr,
    output logic [LANES-1:0]                     lane_en
);
    localparam int PIXW = $clog2(SCR_W * SCR_H);
    localparam int LB   = $clog2(LANES);

    logic signed [15:0] ix, iy;
    logic [PIXW-1:0]    pix;

    assign ix = pos_x[31:16];
    assign iy = pos_y[31:16];

    // Range test on the signed integer parts.
    always_comb begin
        in_range = (ix >= 16'sd0) && (32'(ix) < SCR_W) &&
                   (iy >= 16'sd0) && (32'(iy) < SCR_H);
    end

    // Linear pixel index; only meaningful when in range.
    always_comb begin
        pix = PIXW'(iy[14:0]) * PIXW'(SCR_W) + PIXW'(ix[14:0]);
    end

    assign word_addr = pix[PIXW-1:LB];

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane_en[g] = (pix[LB-1:0] == LB'(g));
        end
    endgenerate
endmodule

// File: rtl/gfx_plot_engine.sv
// Top of the point-plot engine. It queues commands and runs one command
// per activation: idle -> exec -> (write) -> idle. It assumes mem_ack is
// raised only while mem_req is high.
module gfx_plot_engine
    import gfx_plot_pkg::*;
#(
    parameter int SCR_W      = 400,
    parameter int SCR_H      = 300,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr,
    input  logic [OP_BITS-1:0]   cmd_op,
    input  logic [ARG_BITS-1:0]  cmd_arg,
    output logic                 cmd_full,
    output logic                 mem_req,
    output logic [$clog2(SCR_W*SCR_H)-$clog2(LANES)-1:0] mem_addr,
    output logic [LANES-1:0]     mem_lane_en,
    output logic [WORD_BITS-1:0] mem_wdata,
    input  logic                 mem_ack
);
    localparam int WORD_AW  = $clog2(SCR_W * SCR_H) - $clog2(LANES);
    localparam int WORD_CNT = (SCR_W * SCR_H) / LANES;
    localparam int CMD_W    = OP_BITS + ARG_BITS;

    gfx_cmd_t               q_head, cur;
    logic                   q_empty, q_pop;
    seq_state_e             state;
    logic [ARG_BITS-1:0]    pen_x, pen_y;
    logic [PIX_BITS-1:0]    colour;
    logic                   hit;
    logic [WORD_AW-1:0]     calc_addr;
    logic [LANES-1:0]       calc_lane;

    gfx_cmd_fifo #(.DW(CMD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (cmd_wr),
        .push_data ({cmd_op, cmd_arg}),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (cmd_full)
    );

    gfx_pix_addr #(.SCR_W(SCR_W), .SCR_H(SCR_H), .LANES(LANES)) u_addr (
        .pos_x     (pen_x),
        .pos_y     (pen_y),
        .in_range  (hit),
        .word_addr (calc_addr),
        .lane_en   (calc_lane)
    );

    // Pop one command each time the sequencer wakes from idle.
    assign q_pop = (state == SEQ_IDLE) && !q_empty;

    // Write data replicates the colour into every lane.
    assign mem_wdata = {LANES{colour}};
    assign mem_req   = (state == SEQ_WRITE);

    // Sequencer: one command per activation, then back to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SEQ_IDLE;
            cur         <= '0;
            pen_x       <= '0;
            pen_y       <= '0;
            colour      <= '0;
            mem_addr    <= '0;
            mem_lane_en <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (!q_empty) begin
                        cur   <= q_head;
                        state <= SEQ_EXEC;
                    end
                end
                SEQ_EXEC: begin
                    state <= SEQ_IDLE;
                    case (cur.op)
                        OP_SET_X: pen_x  <= cur.arg;
                        OP_SET_Y: pen_y  <= cur.arg;
                        OP_COLOR: colour <= cur.arg[PIX_BITS-1:0];
                        OP_PLOT: begin
                            if (hit) begin
                                mem_addr    <= calc_addr;
                                mem_lane_en <= calc_lane;
                                state       <= SEQ_WRITE;
                            end
                        end
                        default: ;
                    endcase
                end
                SEQ_WRITE: begin
                    if (mem_ack) state <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/gfx_plot_checker.sv
// Protocol checker for the memory side of the point-plot engine.
// Assumes mem_ack comes only while mem_req is high.
module gfx_plot_checker #(
    parameter int WAW        = 15,
    parameter int WORD_LIMIT = 30000
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mem_req,
    input logic           mem_ack,
    input logic [WAW-1:0] mem_addr,
    input logic [3:0]     mem_lane_en,
    input logic [63:0]    mem_wdata
);
    // R8: request and payload held until acknowledged.
    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_lane_en) && $stable(mem_wdata)));

    // R8: one write per plot; the request drops after the acknowledge.
    assert_req_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);

    // R6: exactly one lane enabled during a write.
    assert_lane_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_lane_en) == 1));

    // R7: a write never targets a word outside the screen.
    assert_addr_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (32'(mem_addr) < WORD_LIMIT));
endmodule

bind gfx_plot_engine gfx_plot_checker #(.WAW(WORD_AW), .WORD_LIMIT(WORD_CNT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .mem_lane_en (mem_lane_en),
    .mem_wdata   (mem_wdata)
);

// File: tb/gfx_plot_engine_bench.sv
module gfx_plot_engine_bench;
    localparam int W = 400, H = 300, DEPTH = 8, WAW = 15, MAXW = 1024;

    logic        clk = 0, rst_n = 0;
    logic        cmd_wr = 0;
    logic [3:0]  cmd_op = 0;
    logic [31:0] cmd_arg = 0;
    logic        cmd_full, mem_req, mem_ack = 0;
    logic [WAW-1:0] mem_addr;
    logic [3:0]  mem_lane_en;
    logic [63:0] mem_wdata;

    gfx_plot_engine #(.SCR_W(W), .SCR_H(H), .FIFO_DEPTH(DEPTH)) u_gfx_plot_engine (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .cmd_full(cmd_full), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_lane_en(mem_lane_en), .mem_wdata(mem_wdata), .mem_ack(mem_ack));

    always #2 clk = ~clk;

    int checks = 0, fails = 0;
    int n_exp = 0, n_got = 0;
    logic [WAW-1:0] e_addr [MAXW];
    logic [3:0]     e_lane [MAXW];
    logic [63:0]    e_data [MAXW];
    logic [31:0] m_x = 0, m_y = 0;
    logic [15:0] m_col = 0;
    bit hold_ack = 0;
    bit done = 0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model of one accepted command.
    task automatic model(logic [3:0] op, logic [31:0] arg);
        int xi, yi, p;
        case (op)
            4'd1: m_x = arg;
            4'd2: m_y = arg;
            4'd3: m_col = arg[15:0];
            4'd4: begin
                xi = int'($signed(m_x[31:16]));
                yi = int'($signed(m_y[31:16]));
                if (xi >= 0 && xi < W && yi >= 0 && yi < H && n_exp < MAXW) begin
                    p = yi * W + xi;
                    e_addr[n_exp] = WAW'(p >> 2);
                    e_lane[n_exp] = 4'(1 << (p % 4));
                    e_data[n_exp] = {4{m_col}};
                    n_exp++;
                end
            end
            default: ;   // R2, R11: no effect
        endcase
    endtask

    task automatic push(logic [3:0] op, logic [31:0] arg);
        @(negedge clk);
        while (cmd_full) @(negedge clk);
        cmd_wr = 1; cmd_op = op; cmd_arg = arg;
        model(op, arg);
        @(negedge clk);
        cmd_wr = 0;
    endtask

    function automatic logic [31:0] coord(int lim);
        int v = int'($urandom_range(0, lim + 15)) - 8;
        return {16'(v), 16'($urandom)};
    endfunction

    // Memory responder: acks a pending request after 0..2 cycles and scores it.
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            mem_ack = 0;
            if (mem_req && !hold_ack) begin
                if (dly == 0) begin
                    if (n_got < n_exp) begin
                        check(mem_addr == e_addr[n_got], "R5", "word address", mem_addr, e_addr[n_got]);
                        check(mem_lane_en == e_lane[n_got], "R6", "lane enable", mem_lane_en, e_lane[n_got]);
                        check(mem_wdata == e_data[n_got], "R6", "write data (R4 colour)", mem_wdata, e_data[n_got]);
                    end else begin
                        check(0, "R7", "unexpected write (R2/R11/R10)", n_got + 1, n_exp);
                    end
                    n_got++;
                    mem_ack = 1;
                    dly = int'($urandom_range(0, 2));
                end else dly--;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(0, "ALL", "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic drain();
        int t = 0;
        while ((n_got < n_exp) && t < 5000) begin @(negedge clk); t++; end
        repeat (10) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd7771));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(mem_req == 0, "R1", "mem_req after reset", mem_req, 0);
        check(cmd_full == 0, "R1", "cmd_full after reset", cmd_full, 0);
        repeat (20) @(negedge clk);
        check(n_got == 0, "R1", "no write while queue idle", n_got, 0);

        // R2, R11: NOP and unknown codes, no writes
        push(4'd0, 32'hFFFF_FFFF);
        for (int k = 5; k < 16; k++) push(4'(k), 32'h0001_0001);
        repeat (40) @(negedge clk);
        check(n_got == 0, "R2", "no write from NOP/unknown codes (R11)", n_got, 0);

        // Directed corners: R3 fraction ignored, R5 corners, R6 lanes
        push(4'd3, 32'hABCD_1234);
        push(4'd1, 32'h0000_FFFF); push(4'd2, 32'h0000_0001); push(4'd4, 0);
        push(4'd1, 32'h018F_8000); push(4'd2, 32'h012B_FFFF); push(4'd4, 0);
        push(4'd1, 32'h0003_0000); push(4'd4, 0);
        push(4'd1, 32'h0190_0000); push(4'd4, 0);   // R7: x = 400
        push(4'd1, 32'hFFFF_0000); push(4'd4, 0);   // R7: x = -1
        push(4'd1, 32'h0000_0000); push(4'd2, 32'h012C_0000); push(4'd4, 0); // R7: y = 300
        drain();
        check(n_got == n_exp, "R7", "write count after corners", n_got, n_exp);

        // R10: fill the queue with the ack held, then a refused write
        hold_ack = 1;
        push(4'd2, 32'h0005_0000); push(4'd1, 32'h0001_0000); push(4'd4, 0);
        repeat (6) @(negedge clk);
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            cmd_wr = 1; cmd_op = 4'd1; cmd_arg = {16'(10 + k), 16'h0};
            model(4'd1, {16'(10 + k), 16'h0});
            @(negedge clk); cmd_wr = 0;
        end
        @(negedge clk);
        check(cmd_full == 1, "R10", "full after DEPTH queued (R9 accept while waiting)", cmd_full, 1);
        cmd_wr = 1; cmd_op = 4'd4; cmd_arg = 0;     // refused, not modelled
        @(negedge clk); cmd_wr = 0;
        check(cmd_full == 1, "R10", "still full after refused write", cmd_full, 1);
        hold_ack = 0;
        push(4'd4, 0);   // plots at x = 17 (last queued X), y = 5
        drain();
        check(n_got == n_exp, "R10", "refused write left no trace", n_got, n_exp);

        // R9, R3..R7: constrained random stream
        for (int i = 0; i < 400; i++) begin
            case ($urandom_range(0, 9))
                0, 1:    push(4'd1, coord(W));
                2, 3:    push(4'd2, coord(H));
                4:       push(4'd3, $urandom);
                5:       push(4'($urandom_range(5, 15)), $urandom);
                6:       push(4'd0, $urandom);
                default: push(4'd4, $urandom);
            endcase
        end
        drain();
        check(n_got == n_exp, "R9", "write count after random stream", n_got, n_exp);
        check(mem_req == 0, "R8", "request idle at end", mem_req, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule